// File: doc/BRIEF.md
# Chunked Firmware DMA Transfer Engine

This block copies firmware images into a small controller's local storage one 256-byte chunk at a time. Software programs a base register holding an external address divided by 256, a byte offset into the external window, and a byte offset into the chosen local memory. A write to the command register then launches the copy. The destination is either the instruction memory or the data memory, as picked by a bit in the command word.

The engine reads the external window through a simple word-read port: it raises a request with a byte address and waits for a one-cycle acknowledge carrying the data, however many cycles that takes. Every acknowledged word is written straight into the chosen local memory. A chunk is always 64 words. An idle flag in the command register drops while a chunk is being moved and rises again once it is complete. Commands that cannot be honoured set a sticky error flag, which a write to the control register clears. The local memories have a combinational read port so that the attached controller can fetch from them.

The sequencer has three states. IDLE waits for an accepted command (transition *launch*). ISSUE holds the request until the acknowledge; each acknowledge stores one word (transition *beat*), and the acknowledge of word 63 moves to FINISH (transition *last beat*). FINISH lasts one cycle and returns to IDLE (transition *retire*).

Top module: `chunk_dma`

## Requirements
- R1: After reset the base, local-offset, external-offset and control registers read 0, the command register reads 0x0000_0002 (idle set, error clear), and `ext_req` is low.
- R2: Register indices on `reg_addr` are 0 base, 1 local offset, 2 external offset, 3 command, 4 control. A write to indices 0, 1, 2 or 4 is read back unchanged.
- R3: A command write while idle whose size field (bits 10:8) equals 6 starts a transfer. From the next cycle the idle bit (command read bit 1) is 0. Command read bits 10:8 and bit 4 then show the size and target of the last accepted command.
- R4: A transfer issues exactly 64 word reads. Read k (k = 0..63) uses byte address base*256 + external offset + 4*k, modulo 2^32.
- R5: Command bit 4 = 1 targets instruction memory (`mem_rd_sel` = 1) and bit 4 = 0 targets data memory (`mem_rd_sel` = 0). Word k is written to index (local offset / 4 + k) modulo 256 of the target, and the other memory is not written.
- R6: The idle bit returns to 1 exactly two cycles after the edge on which the 64th acknowledge is sampled. The extra cycle is the FINISH state.
- R7: A command write while not idle is ignored: the running transfer, both memories and the latched command fields are unchanged. It also sets the sticky error bit (command read bit 0).
- R8: A command write while idle with a size field other than 6 starts no transfer and sets the error bit.
- R9: Any write to the control register clears the error bit.
- R10: While `ext_req` is high and `ext_ack` is low, `ext_req` stays high and `ext_addr` stays the same on the next cycle, whatever the response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| ext_req | output | 1 | External word read request |
| ext_addr | output | 32 | External byte address of the requested word |
| ext_ack | input | 1 | One-cycle acknowledge with read data |
| ext_rdata | input | 32 | External read data, valid with `ext_ack` |
| mem_rd_sel | input | 1 | Local read select: 1 instruction memory, 0 data memory |
| mem_rd_idx | input | 8 | Local read word index |
| mem_rd_data | output | 32 | Local read data, combinational |

## Verification
The assertions assume that `ext_ack` is raised only while `ext_req` is high, and for at most one cycle per request. The bench's external responder guarantees this: it acknowledges only a pending request, and it always drops the acknowledge on the following cycle. The assertions also assume that register strobes last a single cycle. The bench tasks pulse `reg_we` for one clock and return `reg_addr` to the command index afterwards.

// File: rtl/chunk_dma_pkg.sv
package chunk_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_t;

    localparam int RA_W = 3;
    localparam logic [RA_W-1:0] RA_BASE = 3'd0;
    localparam logic [RA_W-1:0] RA_LOFF = 3'd1;
    localparam logic [RA_W-1:0] RA_EOFF = 3'd2;
    localparam logic [RA_W-1:0] RA_CMD  = 3'd3;
    localparam logic [RA_W-1:0] RA_CTL  = 3'd4;

    localparam int CMD_ERR_BIT  = 0;
    localparam int CMD_IDLE_BIT = 1;
    localparam int CMD_TGT_BIT  = 4;
    localparam int CMD_SIZE_LSB = 8;
    localparam int CMD_SIZE_W   = 3;
    localparam logic [CMD_SIZE_W-1:0] SIZE_CHUNK = 3'd6;

    localparam int TGT_DMEM = 0;
    localparam int TGT_IMEM = 1;
    localparam int N_TGT    = 2;

endpackage

// File: rtl/chunk_dma_regs.sv
module chunk_dma_regs
    import chunk_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RA_W-1:0] addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic            idle_i,
    output logic            start_o,
    output logic            tgt_o,
    output logic [DW-1:0]   base_o,
    output logic [DW-1:0]   loff_o,
    output logic [DW-1:0]   eoff_o
);

    logic [DW-1:0]         base_q, loff_q, eoff_q, ctl_q;
    logic                  err_q, tgt_q;
    logic [CMD_SIZE_W-1:0] size_q;
    logic                  cmd_wr, ctl_wr, size_ok;

    assign cmd_wr  = we && (addr == RA_CMD);
    assign ctl_wr  = we && (addr == RA_CTL);
    assign size_ok = (wdata[CMD_SIZE_LSB +: CMD_SIZE_W] == SIZE_CHUNK);
    assign start_o = cmd_wr && idle_i && size_ok;
    assign tgt_o   = wdata[CMD_TGT_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            loff_q <= '0;
            eoff_q <= '0;
            ctl_q  <= '0;
            err_q  <= 1'b0;
            tgt_q  <= 1'b0;
            size_q <= '0;
        end else begin
            if (we && addr == RA_BASE) base_q <= wdata;
            if (we && addr == RA_LOFF) loff_q <= wdata;
            if (we && addr == RA_EOFF) eoff_q <= wdata;
            if (ctl_wr) begin
                ctl_q <= wdata;
                err_q <= 1'b0;
            end
            if (cmd_wr) begin
                if (start_o) begin
                    tgt_q  <= wdata[CMD_TGT_BIT];
                    size_q <= wdata[CMD_SIZE_LSB +: CMD_SIZE_W];
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_BASE: rdata = base_q;
            RA_LOFF: rdata = loff_q;
            RA_EOFF: rdata = eoff_q;
            RA_CTL:  rdata = ctl_q;
            RA_CMD: begin
                rdata[CMD_ERR_BIT]                   = err_q;
                rdata[CMD_IDLE_BIT]                  = idle_i;
                rdata[CMD_TGT_BIT]                   = tgt_q;
                rdata[CMD_SIZE_LSB +: CMD_SIZE_W]    = size_q;
            end
            default: rdata = '0;
        endcase
    end

    assign base_o = base_q;
    assign loff_o = loff_q;
    assign eoff_o = eoff_q;

    // R7: command while busy flags the sticky error
    assert_busy_cmd_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !idle_i) |=> err_q);

    // R8: unsupported size keeps the engine idle and flags the error
    assert_bad_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && idle_i && !size_ok) |=> (err_q && idle_i));

    // R9: control write clears the error
    assert_ctl_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !err_q);

endmodule

// File: rtl/chunk_dma_seq.sv
module chunk_dma_seq
    import chunk_dma_pkg::*;
#(
    parameter int EXT_AW      = 32,
    parameter int DW          = 32,
    parameter int IDX_W       = 8,
    parameter int CHUNK_WORDS = 64,
    parameter int BEAT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tgt_i,
    input  logic [DW-1:0]    base_i,
    input  logic [DW-1:0]    loff_i,
    input  logic [DW-1:0]    eoff_i,
    input  logic             ext_ack_i,
    input  logic [DW-1:0]    ext_rdata_i,
    output logic             idle_o,
    output logic             ext_req_o,
    output logic [EXT_AW-1:0] ext_addr_o,
    output logic [N_TGT-1:0] wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [DW-1:0]    wr_data_o
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(CHUNK_WORDS - 1);

    seq_state_t        state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic [EXT_AW-1:0] xfer_ext_q;
    logic [IDX_W-1:0]  xfer_loc_q;
    logic              tgt_q;
    logic              beat_done, last_beat;

    assign beat_done = (state_q == ST_ISSUE) && ext_ack_i;
    assign last_beat = (beat_q == LAST_BEAT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ISSUE;
            ST_ISSUE:  if (beat_done && last_beat) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            beat_q     <= '0;
            xfer_ext_q <= '0;
            xfer_loc_q <= '0;
            tgt_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                beat_q     <= '0;
                xfer_ext_q <= {base_i[EXT_AW-9:0], 8'h00} + eoff_i[EXT_AW-1:0];
                xfer_loc_q <= loff_i[IDX_W+1:2];
                tgt_q      <= tgt_i;
            end else if (beat_done) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        idle_o    = 1'b0;
        ext_req_o = 1'b0;
        wr_en_o   = '0;
        unique case (state_q)
            ST_IDLE:  idle_o = 1'b1;
            ST_ISSUE: begin
                ext_req_o      = 1'b1;
                wr_en_o[tgt_q] = ext_ack_i;
            end
            ST_FINISH: idle_o = 1'b0;
            default:   idle_o = 1'b0;
        endcase
    end

    assign ext_addr_o = xfer_ext_q + EXT_AW'({beat_q, 2'b00});
    assign wr_idx_o   = xfer_loc_q + IDX_W'(beat_q);
    assign wr_data_o  = ext_rdata_i;

    // R10: request and address hold until acknowledged
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_o && !ext_ack_i) |=> (ext_req_o && $stable(ext_addr_o)));

    // R4: consecutive reads advance by one word
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && !last_beat) |=> (ext_req_o && ext_addr_o == $past(ext_addr_o) + EXT_AW'(4)));

    // R6: idle comes back two cycles after the final acknowledge
    assert_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && last_beat) |=> (!idle_o && !ext_req_o) ##1 idle_o);

endmodule

// File: rtl/chunk_dma_lmem.sv
module chunk_dma_lmem #(
    parameter int WORDS = 256,
    parameter int DW    = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/chunk_dma.sv
module chunk_dma
    import chunk_dma_pkg::*;
#(
    parameter int EXT_AW      = 32,
    parameter int DW          = 32,
    parameter int LM_WORDS    = 256,
    parameter int CHUNK_WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [2:0]                    reg_addr,
    input  logic [DW-1:0]                 reg_wdata,
    output logic [DW-1:0]                 reg_rdata,
    output logic                          ext_req,
    output logic [EXT_AW-1:0]             ext_addr,
    input  logic                          ext_ack,
    input  logic [DW-1:0]                 ext_rdata,
    input  logic                          mem_rd_sel,
    input  logic [$clog2(LM_WORDS)-1:0]   mem_rd_idx,
    output logic [DW-1:0]                 mem_rd_data
);

    localparam int IDX_W  = $clog2(LM_WORDS);
    localparam int BEAT_W = $clog2(CHUNK_WORDS);

    logic             idle, start, tgt;
    logic [DW-1:0]    base, loff, eoff;
    logic [N_TGT-1:0] wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [DW-1:0]    wr_data;
    logic [DW-1:0]    rd_words [N_TGT];

    chunk_dma_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .idle_i  (idle),
        .start_o (start),
        .tgt_o   (tgt),
        .base_o  (base),
        .loff_o  (loff),
        .eoff_o  (eoff)
    );

    chunk_dma_seq #(
        .EXT_AW      (EXT_AW),
        .DW          (DW),
        .IDX_W       (IDX_W),
        .CHUNK_WORDS (CHUNK_WORDS),
        .BEAT_W      (BEAT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .tgt_i       (tgt),
        .base_i      (base),
        .loff_i      (loff),
        .eoff_i      (eoff),
        .ext_ack_i   (ext_ack),
        .ext_rdata_i (ext_rdata),
        .idle_o      (idle),
        .ext_req_o   (ext_req),
        .ext_addr_o  (ext_addr),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_data_o   (wr_data)
    );

    for (genvar t = 0; t < N_TGT; t++) begin : g_lmem
        chunk_dma_lmem #(
            .WORDS (LM_WORDS),
            .DW    (DW),
            .IDX_W (IDX_W)
        ) u_lmem (
            .clk   (clk),
            .we    (wr_en[t]),
            .widx  (wr_idx),
            .wdata (wr_data),
            .ridx  (mem_rd_idx),
            .rdata (rd_words[t])
        );
    end

    assign mem_rd_data = rd_words[mem_rd_sel];

    // R5: at most one local memory written per cycle
    assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R3: an accepted command clears idle on the next cycle
    assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!idle && ext_req));

endmodule

// File: tb/tb_chunk_dma.sv
module tb_chunk_dma;

    localparam int LMW = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_req;
    logic [31:0] ext_addr;
    logic        ext_ack = 1'b0;
    logic [31:0] ext_rdata = '0;
    logic        mem_rd_sel = 1'b0;
    logic [7:0]  mem_rd_idx = '0;
    logic [31:0] mem_rd_data;

    always #10 clk = ~clk;

    chunk_dma dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_req(ext_req), .ext_addr(ext_addr), .ext_ack(ext_ack), .ext_rdata(ext_rdata),
        .mem_rd_sel(mem_rd_sel), .mem_rd_idx(mem_rd_idx), .mem_rd_data(mem_rd_data)
    );

    int checks = 0;
    int fails  = 0;
    bit run_cmp = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    // ---------------- behavioural reference model ----------------
    int          m_state = 0;   // 0 idle, 1 moving, 2 finishing
    int          m_beat  = 0;
    logic [31:0] m_xb    = '0;
    int          m_loc   = 0;
    int          m_tgt   = 0;
    bit          m_err   = 0;
    logic [31:0] sh_base = '0, sh_loff = '0, sh_eoff = '0;
    logic [31:0] bmem [2][LMW];
    bit          bval [2][LMW];

    always @(posedge clk) begin : model
        int old;
        int idx;
        if (!rst_n) begin
            m_state = 0; m_err = 0;
            sh_base = '0; sh_loff = '0; sh_eoff = '0;
        end else begin
            old = m_state;
            if (old == 1 && ext_ack) begin
                idx = (m_loc + m_beat) % LMW;
                bmem[m_tgt][idx] = pattern(m_xb + 32'(4 * m_beat));
                bval[m_tgt][idx] = 1;
                m_beat++;
                if (m_beat == 64) m_state = 2;
            end else if (old == 2) begin
                m_state = 0;
            end
            if (reg_we) begin
                case (reg_addr)
                    3'd0: sh_base = reg_wdata;
                    3'd1: sh_loff = reg_wdata;
                    3'd2: sh_eoff = reg_wdata;
                    3'd3: begin
                        if (old != 0 || reg_wdata[10:8] != 3'd6) m_err = 1;
                        else begin
                            m_state = 1; m_beat = 0;
                            m_tgt = int'(reg_wdata[4]);
                            m_xb  = (sh_base << 8) + sh_eoff;
                            m_loc = int'(sh_loff >> 2) % LMW;
                        end
                    end
                    3'd4: m_err = 0;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- external memory responder ----------------
    int lat_mode = 0;
    int lat_fix  = 0;
    int wcnt     = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ext_ack <= 1'b0;
            wcnt    <= 0;
        end else if (ext_ack) begin
            ext_ack <= 1'b0;
        end else if (ext_req) begin
            if (wcnt == 0) begin
                ext_ack   <= 1'b1;
                ext_rdata <= pattern(ext_addr);
                wcnt      <= (lat_mode != 0) ? int'($urandom_range(3, 0)) : lat_fix;
            end else begin
                wcnt <= wcnt - 1;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk(ext_req == (m_state == 1), "R3 R6 ext_req vs model", 32'(ext_req), 32'(m_state == 1));
            if (m_state == 1)
                chk(ext_addr == m_xb + 32'(4 * m_beat), "R4 R10 ext_addr", ext_addr, m_xb + 32'(4 * m_beat));
            if (reg_addr == 3'd3 && !reg_we) begin
                chk(reg_rdata[1] == (m_state == 0), "R6 idle bit", 32'(reg_rdata[1]), 32'(m_state == 0));
                chk(reg_rdata[0] == m_err, "R7 R8 R9 error bit", 32'(reg_rdata[0]), 32'(m_err));
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0; reg_addr = 3'd3;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a;
        #5 d = reg_rdata;
        reg_addr = 3'd3;
    endtask

    task automatic wait_done();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (m_state != 0 && n < 5000);
        chk(n < 5000, "R6 transfer completes", 32'(n), 32'd5000);
    endtask

    task automatic verify_mem(input string tag);
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < LMW; i++) begin
                if (bval[t][i]) begin
                    mem_rd_sel = t[0];
                    mem_rd_idx = 8'(i);
                    #1;
                    chk(mem_rd_data == bmem[t][i], tag, mem_rd_data, bmem[t][i]);
                end
            end
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R6 actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v;
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < LMW; i++) bval[t][i] = 0;

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        run_cmp = 1;

        // R1 reset state
        rd(3'd0, v); chk(v == 32'h0, "R1 base after reset", v, 32'h0);
        rd(3'd1, v); chk(v == 32'h0, "R1 local offset after reset", v, 32'h0);
        rd(3'd2, v); chk(v == 32'h0, "R1 external offset after reset", v, 32'h0);
        rd(3'd4, v); chk(v == 32'h0, "R1 control after reset", v, 32'h0);
        rd(3'd3, v); chk(v == 32'h2, "R1 command after reset", v, 32'h2);
        chk(ext_req == 1'b0, "R1 ext_req after reset", 32'(ext_req), 32'h0);

        // R2 register readback
        wr(3'd0, 32'h00C0_FFEE); rd(3'd0, v); chk(v == 32'h00C0_FFEE, "R2 base readback", v, 32'h00C0_FFEE);
        wr(3'd1, 32'h0000_0140); rd(3'd1, v); chk(v == 32'h0000_0140, "R2 local offset readback", v, 32'h0000_0140);
        wr(3'd2, 32'h1357_9BDF); rd(3'd2, v); chk(v == 32'h1357_9BDF, "R2 external offset readback", v, 32'h1357_9BDF);
        wr(3'd4, 32'hA5A5_0001); rd(3'd4, v); chk(v == 32'hA5A5_0001, "R2 control readback", v, 32'hA5A5_0001);

        // T1: instruction memory, fixed latency 2
        lat_mode = 0; lat_fix = 2;
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h0000_ABCD);
        wr(3'd2, 32'h0000_0040);
        wr(3'd1, 32'h0000_0000);
        wr(3'd3, 32'h0000_0610);
        wait_done();
        verify_mem("R5 instruction memory after T1");
        rd(3'd3, v); chk(v == 32'h0000_0612, "R3 command fields after T1", v, 32'h0000_0612);

        // T2: data memory, same indices, random latency; instruction memory untouched
        lat_mode = 1;
        wr(3'd2, 32'h0000_1000);
        wr(3'd3, 32'h0000_0600);
        wait_done();
        verify_mem("R5 both memories after T2");
        rd(3'd3, v); chk(v == 32'h0000_0602, "R3 command fields after T2", v, 32'h0000_0602);

        // T3: instruction memory, index wrap, busy command in flight
        wr(3'd0, 32'hFFFF_FF00);
        wr(3'd2, 32'h0000_0004);
        wr(3'd1, 32'h0000_03C0);
        wr(3'd3, 32'h0000_0610);
        repeat (20) @(posedge clk);
        wr(3'd3, 32'h0000_0600);
        wait_done();
        verify_mem("R5 R7 memories after busy command and wrap");
        rd(3'd3, v); chk(v == 32'h0000_0613, "R7 error set, fields kept", v, 32'h0000_0613);
        wr(3'd4, 32'h0);
        rd(3'd3, v); chk(v == 32'h0000_0612, "R9 error cleared by control write", v, 32'h0000_0612);

        // R8 unsupported size
        wr(3'd3, 32'h0000_0500);
        repeat (6) @(negedge clk);
        chk(ext_req == 1'b0, "R8 no transfer for bad size", 32'(ext_req), 32'h0);
        rd(3'd3, v); chk(v == 32'h0000_0613, "R8 error set, idle, fields kept", v, 32'h0000_0613);
        verify_mem("R8 memories unchanged");
        wr(3'd4, 32'h0);
        rd(3'd3, v); chk(v == 32'h0000_0612, "R9 error cleared again", v, 32'h0000_0612);

        // T4: data memory at offset with zero latency
        lat_mode = 0; lat_fix = 0;
        wr(3'd0, 32'h0000_0012);
        wr(3'd2, 32'h0000_0080);
        wr(3'd1, 32'h0000_0200);
        wr(3'd3, 32'h0000_0600);
        wait_done();
        verify_mem("R4 R5 memories after T4");

        repeat (4) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule